// File: doc/BRIEF.md
# SRAM Dual-Rail Access Sequencer

This controller sits beside a dual-supply SRAM macro whose periphery runs on a variable rail that follows dynamic voltage scaling. A fixed high rail is also present. Each accepted access carries a 13-bit word address. The upper six bits pick one of 64 cell blocks and the lower seven bits pick one of 128 rows. Only the addressed block has its rails moved. A read leaves the block's cells on the high rail and lets the wordline swing to the variable rail only. A write drops the block's cells to the variable rail and lifts its wordline to the high rail. Every other block keeps its idle setting: cells on the high rail and wordline grounded.

The sequencer waits for an asynchronous rail-settled acknowledge before it raises any wordline. It lowers the wordline before the rails go back to idle. On a write it holds write enable until an asynchronous dummy-wordline feedback reports that the wordline has reached ground. Both acknowledges pass through two-flop synchronisers. A programmable limit on waiting cycles raises an error flag and aborts the access if an acknowledge never comes.

Top module: `sram_rail_seq`

## Requirements
- R1: While the wordline window is open, `row_sel_o` is one-hot at `addr_i[6:0]` and `blk_wl_en_o` is one-hot at `addr_i[12:7]` of the accepted request. Both are all-zero outside that window.
- R2: During a read, every bit of `csup_hi_n_o` is 0 (high rail for all cells) and every bit of `wlv_hi_n_o` is 1 (wordlines on the variable rail).
- R3: From acceptance of a write until the cycle after it finishes, only bit `blk` of `csup_hi_n_o` is 1 (variable rail) and only bit `blk` of `wlv_hi_n_o` is 0 (high rail).
- R4: After reset and when idle, `csup_hi_n_o` is all 0, `wlv_hi_n_o` is all 1, and no wordline, write enable, sense enable or precharge disable is asserted.
- R5: The wordline window opens only after the rail acknowledge has been seen high through the synchroniser, and at least 2 cycles after the rails were set. The rail selects do not change while the window is open.
- R6: On a read, `sense_en_o` is high for exactly the one cycle after the window opens, and the window closes together with it. `sense_en_o` is never high during a write.
- R7: `precharge_off_o` is high in exactly the cycles in which the wordline window is open.
- R8: A write opens the window with write enable high and keeps it open until the synchronised dummy-wordline-low input reads 0. The write then closes the window and keeps write enable high until that input reads 1 again.
- R9: A request is taken only when `busy_o` is 0. Requests presented while busy have no effect on any output.
- R10: If a wait for an acknowledge lasts `tmo_lim_i` cycles, `err_o` is set, the access is aborted and the block returns to idle. `err_o` is cleared when the next request is accepted.
- R11: While a write has its window open, the accessed block never has both its cell supply and its wordline on the high rail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, taken when not busy |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 13 | Word address: block in [12:7], row in [6:0] |
| tmo_lim_i | input | 8 | Maximum wait cycles for an acknowledge |
| rail_ok_ai | input | 1 | Asynchronous rail-settled acknowledge |
| dwl_low_ai | input | 1 | Asynchronous dummy-wordline-at-ground feedback |
| busy_o | output | 1 | Access sequence in progress |
| err_o | output | 1 | Acknowledge timeout occurred |
| csup_hi_n_o | output | 64 | Per-block cell-supply select, 0 = high rail |
| wlv_hi_n_o | output | 64 | Per-block wordline-level select, 0 = high rail |
| row_sel_o | output | 128 | Global row select |
| blk_wl_en_o | output | 64 | Local wordline enable per block |
| write_en_o | output | 1 | Write driver enable |
| sense_en_o | output | 1 | Sense amplifier enable |
| precharge_off_o | output | 1 | Bitline precharge disable |

## Verification
The hardest case to reach is a read or write that goes straight into the opposite operation on the same block. The rail acknowledge must fall and rise again across the synchroniser while the guard cycles are still counting. The bench builds this with a delayed-acknowledge model that pulls the rail acknowledge low whenever the write mask changes. It issues same-block read/write pairs back to back and compares every output each cycle against its own model. The timeout paths are reached by holding one acknowledge stuck, first the rail one and then the dummy wordline.

// File: rtl/sram_rail_pkg.sv
package sram_rail_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RAIL = 3'd1,
        ST_ACT  = 3'd2,
        ST_SNS  = 3'd3,
        ST_WEND = 3'd4,
        ST_REL  = 3'd5
    } seq_st_e;
endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/seq_onehot.sv
module seq_onehot #(
    parameter int N = 64,
    parameter int W = 6
) (
    input  logic         en_i,
    input  logic [W-1:0] idx_i,
    output logic [N-1:0] sel_o
);
    for (genvar i = 0; i < N; i++) begin : g_dec
        assign sel_o[i] = en_i && (idx_i == W'(i));
    end
endmodule

// File: rtl/sram_rail_seq.sv
module sram_rail_seq
    import sram_rail_pkg::*;
#(
    parameter int BLK_W       = 6,
    parameter int ROW_W       = 7,
    parameter int TO_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_i,
    input  logic                        wr_i,
    input  logic [BLK_W+ROW_W-1:0]      addr_i,
    input  logic [TO_W-1:0]             tmo_lim_i,
    input  logic                        rail_ok_ai,
    input  logic                        dwl_low_ai,
    output logic                        busy_o,
    output logic                        err_o,
    output logic [(1<<BLK_W)-1:0]       csup_hi_n_o,
    output logic [(1<<BLK_W)-1:0]       wlv_hi_n_o,
    output logic [(1<<ROW_W)-1:0]       row_sel_o,
    output logic [(1<<BLK_W)-1:0]       blk_wl_en_o,
    output logic                        write_en_o,
    output logic                        sense_en_o,
    output logic                        precharge_off_o
);
    localparam int ADDR_W = BLK_W + ROW_W;
    localparam int NBLK   = 1 << BLK_W;
    localparam int NROW   = 1 << ROW_W;
    localparam logic [TO_W-1:0] GUARD = TO_W'(SYNC_STAGES);

    typedef struct packed {
        seq_st_e          st;
        logic [BLK_W-1:0] blk;
        logic [ROW_W-1:0] row;
        logic             wr;
        logic             rail;
        logic             wl;
        logic             pcd;
        logic             we;
        logic             se;
        logic             err;
        logic [TO_W-1:0]  tmr;
    } seq_t;

    seq_t q, d;
    logic rail_ok_s, dwl_low_s;
    logic timed_out;
    logic [NBLK-1:0] wr_mask;

    seq_sync #(.STAGES(SYNC_STAGES)) u_sync_rail (
        .clk(clk), .rst_n(rst_n), .d_i(rail_ok_ai), .q_o(rail_ok_s)
    );
    seq_sync #(.STAGES(SYNC_STAGES)) u_sync_dwl (
        .clk(clk), .rst_n(rst_n), .d_i(dwl_low_ai), .q_o(dwl_low_s)
    );

    assign timed_out = (q.tmr == tmo_lim_i);

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_i) begin
                    d.st   = ST_RAIL;
                    d.blk  = addr_i[ADDR_W-1 -: BLK_W];
                    d.row  = addr_i[ROW_W-1:0];
                    d.wr   = wr_i;
                    d.rail = 1'b1;
                    d.tmr  = '0;
                    d.err  = 1'b0;
                end
            end
            ST_RAIL: begin
                d.tmr = q.tmr + TO_W'(1);
                if (rail_ok_s && (q.tmr >= GUARD)) begin
                    d.st  = ST_ACT;
                    d.wl  = 1'b1;
                    d.pcd = 1'b1;
                    d.we  = q.wr;
                    d.tmr = '0;
                end else if (timed_out) begin
                    d.err = 1'b1;
                    d.st  = ST_REL;
                end
            end
            ST_ACT: begin
                d.tmr = q.tmr + TO_W'(1);
                if (!q.wr) begin
                    d.st = ST_SNS;
                    d.se = 1'b1;
                end else if (!dwl_low_s) begin
                    d.st  = ST_WEND;
                    d.wl  = 1'b0;
                    d.pcd = 1'b0;
                    d.tmr = '0;
                end else if (timed_out) begin
                    d.err = 1'b1;
                    d.wl  = 1'b0;
                    d.pcd = 1'b0;
                    d.we  = 1'b0;
                    d.st  = ST_REL;
                end
            end
            ST_SNS: begin
                d.se  = 1'b0;
                d.wl  = 1'b0;
                d.pcd = 1'b0;
                d.st  = ST_REL;
            end
            ST_WEND: begin
                d.tmr = q.tmr + TO_W'(1);
                if (dwl_low_s) begin
                    d.we = 1'b0;
                    d.st = ST_REL;
                end else if (timed_out) begin
                    d.err = 1'b1;
                    d.we  = 1'b0;
                    d.st  = ST_REL;
                end
            end
            ST_REL: begin
                d.rail = 1'b0;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    seq_onehot #(.N(NBLK), .W(BLK_W)) u_dec_mask (
        .en_i(q.rail && q.wr), .idx_i(q.blk), .sel_o(wr_mask)
    );
    seq_onehot #(.N(NBLK), .W(BLK_W)) u_dec_blk (
        .en_i(q.wl), .idx_i(q.blk), .sel_o(blk_wl_en_o)
    );
    seq_onehot #(.N(NROW), .W(ROW_W)) u_dec_row (
        .en_i(q.wl), .idx_i(q.row), .sel_o(row_sel_o)
    );

    assign csup_hi_n_o     = wr_mask;
    assign wlv_hi_n_o      = ~wr_mask;
    assign busy_o          = (q.st != ST_IDLE);
    assign err_o           = q.err;
    assign write_en_o      = q.we;
    assign sense_en_o      = q.se;
    assign precharge_off_o = q.pcd;
endmodule

// File: rtl/sram_rail_seq_chk.sv
module sram_rail_seq_chk #(
    parameter int NBLK = 64,
    parameter int NROW = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy_o,
    input logic [NBLK-1:0] csup_hi_n_o,
    input logic [NBLK-1:0] wlv_hi_n_o,
    input logic [NROW-1:0] row_sel_o,
    input logic [NBLK-1:0] blk_wl_en_o,
    input logic            write_en_o,
    input logic            sense_en_o,
    input logic            precharge_off_o
);
    logic wl_on;
    assign wl_on = |blk_wl_en_o;

    a_r1_blk_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(blk_wl_en_o) && $onehot0(row_sel_o));

    a_r1_row_with_blk: assert property (@(posedge clk) disable iff (!rst_n)
        (|row_sel_o) == wl_on);

    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!wl_on && !write_en_o && !sense_en_o && csup_hi_n_o == '0));

    a_r5_rails_before_wl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wl_on) |-> ($stable(csup_hi_n_o) && $stable(wlv_hi_n_o)));

    a_r5_rails_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wl_on && $past(wl_on)) |-> ($stable(csup_hi_n_o) && $stable(wlv_hi_n_o)));

    a_r6_sense_after_wl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sense_en_o) |-> $past(wl_on));

    a_r6_no_sense_write: assert property (@(posedge clk) disable iff (!rst_n)
        sense_en_o |-> !write_en_o);

    a_r7_precharge_window: assert property (@(posedge clk) disable iff (!rst_n)
        precharge_off_o == wl_on);

    a_r8_we_after_wl: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(write_en_o) |-> !wl_on);

    a_r11_not_both_high: assert property (@(posedge clk) disable iff (!rst_n)
        (write_en_o && wl_on) |->
            (((csup_hi_n_o & blk_wl_en_o) == blk_wl_en_o) && ((wlv_hi_n_o & blk_wl_en_o) == '0)));
endmodule

bind sram_rail_seq sram_rail_seq_chk #(.NBLK(NBLK), .NROW(NROW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o),
    .csup_hi_n_o(csup_hi_n_o), .wlv_hi_n_o(wlv_hi_n_o),
    .row_sel_o(row_sel_o), .blk_wl_en_o(blk_wl_en_o),
    .write_en_o(write_en_o), .sense_en_o(sense_en_o),
    .precharge_off_o(precharge_off_o)
);

// File: tb/sram_rail_seq_test.sv
module sram_rail_seq_test;
    localparam int RAIL_DLY = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, wr = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  tmo_lim = 8'd20;
    logic rail_ok = 1'b1, dwl_low = 1'b1;
    logic busy_o, err_o, write_en_o, sense_en_o, precharge_off_o;
    logic [63:0]  csup_hi_n_o, wlv_hi_n_o, blk_wl_en_o;
    logic [127:0] row_sel_o;

    int vecs = 0, errs = 0, cycles = 0;
    bit stuck_rail = 0, stuck_dwl = 0;

    always #10 clk = ~clk;

    sram_rail_seq uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
        .tmo_lim_i(tmo_lim), .rail_ok_ai(rail_ok), .dwl_low_ai(dwl_low),
        .busy_o(busy_o), .err_o(err_o), .csup_hi_n_o(csup_hi_n_o),
        .wlv_hi_n_o(wlv_hi_n_o), .row_sel_o(row_sel_o), .blk_wl_en_o(blk_wl_en_o),
        .write_en_o(write_en_o), .sense_en_o(sense_en_o),
        .precharge_off_o(precharge_off_o)
    );

    // Analog side: rail settle delay after any mask change, dummy wordline tracks wordline
    logic [63:0] prev_mask = '0;
    int  rail_cnt = 0;
    logic [3:0] wl_hist = '0;
    always @(negedge clk) begin
        if (csup_hi_n_o !== prev_mask) rail_cnt = RAIL_DLY;
        else if (rail_cnt > 0) rail_cnt = rail_cnt - 1;
        prev_mask = csup_hi_n_o;
        rail_ok = (rail_cnt == 0) && !stuck_rail;
        wl_hist = {wl_hist[2:0], |blk_wl_en_o};
        dwl_low = stuck_dwl ? 1'b1 : !wl_hist[1];
    end

    // Behavioural reference model, stepped on each rising edge
    int m_ph, m_tmr, m_blk, m_row;
    bit m_wl, m_se, m_we, m_err, m_rail, m_wr;
    bit hr[$], hd[$];
    always @(posedge clk) begin
        bit rs, ds;
        if (!rst_n) begin
            m_ph = 0; m_tmr = 0; m_blk = 0; m_row = 0;
            m_wl = 0; m_se = 0; m_we = 0; m_err = 0; m_rail = 0; m_wr = 0;
            hr = '{0, 0}; hd = '{0, 0};
        end else begin
            rs = hr.pop_front(); ds = hd.pop_front();
            hr.push_back(rail_ok); hd.push_back(dwl_low);
            case (m_ph)
                0: if (req) begin
                    m_ph = 1; m_blk = addr / 128; m_row = addr % 128; m_wr = wr;
                    m_rail = 1; m_tmr = 0; m_err = 0;
                end
                1: begin
                    if (rs && m_tmr >= 2) begin m_ph = 2; m_wl = 1; m_we = m_wr; m_tmr = 0; end
                    else if (m_tmr == tmo_lim) begin m_err = 1; m_ph = 5; end
                    else m_tmr++;
                end
                2: begin
                    if (!m_wr) begin m_ph = 3; m_se = 1; end
                    else if (!ds) begin m_ph = 4; m_wl = 0; m_tmr = 0; end
                    else if (m_tmr == tmo_lim) begin m_err = 1; m_wl = 0; m_we = 0; m_ph = 5; end
                    else m_tmr++;
                end
                3: begin m_se = 0; m_wl = 0; m_ph = 5; end
                4: begin
                    if (ds) begin m_we = 0; m_ph = 5; end
                    else if (m_tmr == tmo_lim) begin m_err = 1; m_we = 0; m_ph = 5; end
                    else m_tmr++;
                end
                default: begin m_rail = 0; m_ph = 0; end
            endcase
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [127:0] er, eb, em;
        if (rst_n) begin
            er = '0; eb = '0; em = '0;
            if (m_wl) begin er[m_row] = 1'b1; eb[m_blk] = 1'b1; end
            if (m_rail && m_wr) em[m_blk] = 1'b1;
            chk("R1 row select", 128'(row_sel_o), er);
            chk("R1 R5 block wordline", 128'(blk_wl_en_o), eb);
            chk("R2 R3 R4 cell supply select", 128'(csup_hi_n_o), em);
            chk("R2 R3 R11 wordline level select", 128'(wlv_hi_n_o), {64'd0, ~em[63:0]});
            chk("R8 write enable", 128'(write_en_o), 128'(m_we));
            chk("R6 sense enable", 128'(sense_en_o), 128'(m_se));
            chk("R7 precharge disable", 128'(precharge_off_o), 128'(m_wl));
            chk("R9 busy", 128'(busy_o), 128'(m_ph != 0));
            chk("R10 error flag", 128'(err_o), 128'(m_err));
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o) @(negedge clk);
    endtask

    task automatic access(input logic [12:0] a, input logic w);
        wait_idle();
        req = 1'b1; addr = a; wr = w;
        @(negedge clk);
        req = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: reset state
        chk("R4 reset cell supply", 128'(csup_hi_n_o), '0);
        chk("R4 reset wordline level", 128'(wlv_hi_n_o), {64'd0, {64{1'b1}}});
        chk("R4 reset strobes", 128'({busy_o, write_en_o, sense_en_o, precharge_off_o}), '0);

        access(13'h0000, 1'b0);          // R2 read, first block/row
        access(13'h1FFF, 1'b1);          // R3 write, last block/row
        access(13'h0A5A, 1'b0);          // R5 read then write, same block
        access(13'h0A11, 1'b1);
        access(13'h0C03, 1'b1);          // write then read, same block
        access(13'h0C7F, 1'b0);
        wait_idle();

        // R9: requests while busy are ignored
        access(13'h1234, 1'b0);
        for (int i = 0; i < 5; i++) begin
            req = 1'b1; addr = 13'h0777; wr = 1'b1;
            @(negedge clk);
        end
        req = 1'b0;
        wait_idle();

        // R10: rail acknowledge never returns
        stuck_rail = 1;
        access(13'h0100, 1'b1);
        wait_idle();
        chk("R10 rail timeout flag", 128'(err_o), 128'(1));
        stuck_rail = 0;
        repeat (8) @(negedge clk);
        access(13'h0101, 1'b0);
        wait_idle();
        chk("R10 flag cleared", 128'(err_o), 128'(0));

        // R10: dummy wordline never rises
        stuck_dwl = 1;
        access(13'h0200, 1'b1);
        wait_idle();
        chk("R10 dummy timeout flag", 128'(err_o), 128'(1));
        stuck_dwl = 0;
        repeat (4) @(negedge clk);

        for (int i = 0; i < 16; i++) access(13'((i * 509) % 8192), i[0]);
        wait_idle();
        repeat (10) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule